// File: doc/BRIEF.md
# Block-Scaled FP8 to BF16 Expander

This block takes one block of 32 eight-bit floating-point elements together with a single shared scale byte and turns it into 32 BF16 values, one per clock, for a 16-bit multiply-add datapath. The scale byte encodes only a power of two, so applying it is an integer addition on the exponent of each decoded element; no floating-point multiplier is involved. A mode input selects whether the element bytes use the 4-bit-exponent/3-bit-mantissa layout or the 5-bit-exponent/2-bit-mantissa layout.

A producer presents a block with `blk_valid`; the block is captured in one cycle when `blk_ready` is high. Results then stream out under `res_valid`/`res_ready`, tagged with their element index and a last marker. Each element is classified (zero, finite, infinity, NaN), subnormal elements are normalized, the scale exponent is added, and the result is packed into BF16 with overflow to infinity and gradual underflow by truncation.

Top module: `mxfp8_expand`

## Requirements
- R1: Scale code 0xFF forces every one of the 32 results of that block to 0x7FC0, whatever the element codes.
- R2: For any other scale code X, a finite nonzero element of value v yields v·2^(X−127); when that lies in the BF16 normal range it is produced exactly.
- R3: With `blk_fmt`=0 an element byte is sign[7], exponent[6:3] with bias 7, mantissa[2:0]; only exponent 15 with mantissa 7 is NaN, and there is no infinity (exponent 15 with mantissa 0..6 is finite).
- R4: With `blk_fmt`=1 an element byte is sign[7], exponent[6:2] with bias 15, mantissa[1:0]; exponent 31 with mantissa 0 gives signed infinity 0x7F80/0xFF80, with nonzero mantissa a NaN output {sign, 0xFF, 0x40}. A NaN element in mode 0 gives the same NaN form.
- R5: Elements with exponent field 0 and nonzero mantissa are subnormal (value mantissa·2^(1−bias−mbits)) and are normalized before scaling.
- R6: A scaled result of magnitude 2^128 or more is signed infinity.
- R7: A scaled result below 2^−126 is a BF16 subnormal whose 7-bit fraction is the magnitude divided by 2^−133, truncated toward zero; if that is 0 the output is signed zero.
- R8: Element zeros (exponent and mantissa fields 0) give signed zero for every scale code except 0xFF.
- R9: Element i of a block sits in `blk_elems[8i+7:8i]`; results leave in order i=0..31 with `res_idx`=i, and `res_last` is high only with index 31.
- R10: `blk_ready` is low from the cycle after a block is captured until its last element has moved into the output register; while `res_valid` is high and `res_ready` low, `res_data`, `res_idx` and `res_valid` hold.
- R11: After reset `res_valid` is 0 and `blk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | A block is presented |
| blk_ready | output | 1 | Block can be captured this cycle |
| blk_fmt | input | 1 | 0: 4-bit exponent elements, 1: 5-bit exponent elements |
| blk_scale | input | 8 | Shared power-of-two scale code |
| blk_elems | input | 256 | 32 element bytes, element i in bits 8i+7..8i |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | BF16 result |
| res_idx | output | 5 | Element index of the result |
| res_last | output | 1 | Result is element 31 |

## Verification
Two things can meet in one cycle: the last result of a block sitting stalled in the output register and the capture of the next block, since the input side frees as soon as element 31 leaves the buffer. The bench sends blocks back to back against a pseudo-random consumer stall pattern, so captures regularly land while a stalled result is held. A scoreboard judges it: every result must match, in order, the value computed in real arithmetic for its own block's scale and mode, and each stalled result must be unchanged on the following cycle.

// File: rtl/mxfp8_pkg.sv
package mxfp8_pkg;
  localparam int ELEM_W = 8;
  localparam int BF_W   = 16;
  localparam int EXP_W  = 7;   // unbiased element exponent, signed
  localparam int FRAC_W = 3;   // widest element fraction

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } elem_cls_t;

  typedef struct packed {
    logic                     sign;
    elem_cls_t                cls;
    logic signed [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0]        frac;
  } elem_dec_t;

  localparam logic [7:0]  SCALE_NAN = 8'hFF;
  localparam logic [15:0] BF_QNAN   = 16'h7FC0;
endpackage

// File: rtl/mxfp8_elem_decode.sv
module mxfp8_elem_decode
  import mxfp8_pkg::*;
(
  input  logic [ELEM_W-1:0] code,
  input  logic              fmt,
  output elem_dec_t         dec
);
  logic [3:0] e4;
  logic [2:0] m3;
  logic [4:0] e5;
  logic [1:0] m2;

  assign e4 = code[6:3];
  assign m3 = code[2:0];
  assign e5 = code[6:2];
  assign m2 = code[1:0];

  always_comb begin
    dec      = '0;
    dec.sign = code[7];
    dec.cls  = CLS_FIN;
    if (!fmt) begin
      if (e4 == 4'hF && m3 == 3'h7) begin
        dec.cls = CLS_NAN;
      end else if (e4 == 4'h0) begin
        if (m3 == 3'h0) begin
          dec.cls = CLS_ZERO;
        end else begin
          // value = m * 2^-9; leading one sets the exponent
          casez (m3)
            3'b1??:  begin dec.exp = -7'sd7; dec.frac = {m3[1:0], 1'b0}; end
            3'b01?:  begin dec.exp = -7'sd8; dec.frac = {m3[0], 2'b00};  end
            default: begin dec.exp = -7'sd9; dec.frac = 3'b000;          end
          endcase
        end
      end else begin
        dec.exp  = $signed({3'b000, e4}) - 7'sd7;
        dec.frac = m3;
      end
    end else begin
      if (e5 == 5'h1F) begin
        dec.cls = (m2 == 2'b00) ? CLS_INF : CLS_NAN;
      end else if (e5 == 5'h00) begin
        if (m2 == 2'b00) begin
          dec.cls = CLS_ZERO;
        end else if (m2[1]) begin
          dec.exp  = -7'sd15;
          dec.frac = {m2[0], 2'b00};
        end else begin
          dec.exp  = -7'sd16;
          dec.frac = 3'b000;
        end
      end else begin
        dec.exp  = $signed({2'b00, e5}) - 7'sd15;
        dec.frac = {m2, 1'b0};
      end
    end
  end
endmodule

// File: rtl/mxfp8_scale_apply.sv
module mxfp8_scale_apply
  import mxfp8_pkg::*;
(
  input  elem_dec_t        dec,
  input  logic [7:0]       scale,
  output logic [BF_W-1:0]  bf
);
  localparam int BX_W = 10;

  logic signed [BX_W-1:0] bexp;   // biased BF16 exponent = elem exp + scale code
  logic [BX_W-1:0]        rsh;
  logic [6:0]             wide;
  logic [6:0]             sub;

  assign bexp = BX_W'(dec.exp) + $signed({2'b00, scale});
  assign rsh  = BX_W'(-bexp);
  assign wide = {1'b1, dec.frac, 3'b000};
  assign sub  = (rsh > BX_W'(6)) ? 7'd0 : (wide >> rsh[2:0]);

  always_comb begin
    bf = '0;
    if (scale == SCALE_NAN) begin
      bf = BF_QNAN;
    end else begin
      unique case (dec.cls)
        CLS_NAN:  bf = {dec.sign, 8'hFF, 7'h40};
        CLS_INF:  bf = {dec.sign, 8'hFF, 7'h00};
        CLS_ZERO: bf = {dec.sign, 15'h0000};
        default: begin
          if (bexp >= BX_W'(255))
            bf = {dec.sign, 8'hFF, 7'h00};
          else if (bexp >= BX_W'(1))
            bf = {dec.sign, bexp[7:0], dec.frac, 4'b0000};
          else
            bf = {dec.sign, 8'h00, sub};
        end
      endcase
    end
  end
endmodule

// File: rtl/mxfp8_block_buf.sv
module mxfp8_block_buf
  import mxfp8_pkg::*;
#(
  parameter int N_ELEM = 32,
  localparam int IDX_W = $clog2(N_ELEM)
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     fmt_in,
  input  logic [7:0]               scale_in,
  input  logic [N_ELEM*ELEM_W-1:0] elems_in,
  input  logic                     adv,
  output logic                     busy,
  output logic                     fmt_q,
  output logic [7:0]               scale_q,
  output logic [ELEM_W-1:0]        cur_elem,
  output logic [IDX_W-1:0]         cur_idx,
  output logic                     cur_last
);
  logic [ELEM_W-1:0] mem [N_ELEM];

  for (genvar g = 0; g < N_ELEM; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) mem[g] <= elems_in[g*ELEM_W +: ELEM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cur_idx <= '0;
      fmt_q   <= 1'b0;
      scale_q <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      cur_idx <= '0;
      fmt_q   <= fmt_in;
      scale_q <= scale_in;
    end else if (adv) begin
      if (cur_last) busy <= 1'b0;
      cur_idx <= cur_idx + 1'b1;
    end
  end

  assign cur_elem = mem[cur_idx];
  assign cur_last = (cur_idx == IDX_W'(N_ELEM - 1));

  // R10: a captured block starts at element 0 with the input side closed
  assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> busy && cur_idx == '0);

  // R9: element pointer moves only when an element is consumed
  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !adv && !load |=> $stable(cur_idx));
endmodule

// File: rtl/mxfp8_expand.sv
module mxfp8_expand
  import mxfp8_pkg::*;
#(
  parameter int N_ELEM = 32,
  localparam int IDX_W = $clog2(N_ELEM)
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     blk_valid,
  output logic                     blk_ready,
  input  logic                     blk_fmt,
  input  logic [7:0]               blk_scale,
  input  logic [N_ELEM*ELEM_W-1:0] blk_elems,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [BF_W-1:0]          res_data,
  output logic [IDX_W-1:0]         res_idx,
  output logic                     res_last
);
  logic              busy, fmt_q, cur_last, adv, load;
  logic [7:0]        scale_q;
  logic [ELEM_W-1:0] cur_elem;
  logic [IDX_W-1:0]  cur_idx;
  elem_dec_t         dec;
  logic [BF_W-1:0]   bf;

  assign blk_ready = !busy;
  assign load      = blk_valid && !busy;
  assign adv       = busy && (!res_valid || res_ready);

  mxfp8_block_buf #(.N_ELEM(N_ELEM)) u_buf (
    .clk(clk), .rst(rst), .load(load), .fmt_in(blk_fmt),
    .scale_in(blk_scale), .elems_in(blk_elems), .adv(adv),
    .busy(busy), .fmt_q(fmt_q), .scale_q(scale_q),
    .cur_elem(cur_elem), .cur_idx(cur_idx), .cur_last(cur_last)
  );

  mxfp8_elem_decode u_dec (.code(cur_elem), .fmt(fmt_q), .dec(dec));

  mxfp8_scale_apply u_scl (.dec(dec), .scale(scale_q), .bf(bf));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_idx   <= '0;
      res_last  <= 1'b0;
    end else if (adv) begin
      res_valid <= 1'b1;
      res_data  <= bf;
      res_idx   <= cur_idx;
      res_last  <= cur_last;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R10: a stalled result holds
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_idx));

  // R9: within a block, indices follow one another without gaps
  assert_idx_step_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_ready && !res_last |=> res_valid && res_idx == $past(res_idx) + 1'b1);

  // R9: last marker only on the final index
  assert_last_idx_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_last |-> res_idx == IDX_W'(N_ELEM - 1));

  // R10: input side closed while a block is being expanded
  assert_ready_low_R10: assert property (@(posedge clk) disable iff (rst)
    blk_valid && blk_ready |=> !blk_ready);
endmodule

// File: tb/mxfp8_expand_test.sv
module mxfp8_expand_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         blk_valid, blk_fmt, blk_ready;
  logic [7:0]   blk_scale;
  logic [N*8-1:0] blk_elems;
  logic         res_valid, res_ready, res_last;
  logic [15:0]  res_data;
  logic [4:0]   res_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [15:0] data; logic [4:0] idx; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  mxfp8_expand uut (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_fmt(blk_fmt), .blk_scale(blk_scale), .blk_elems(blk_elems),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_idx(res_idx), .res_last(res_last)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_bf(logic [7:0] c, bit fmt, logic [7:0] sc);
    logic s; int e, m, ex; real mag, x;
    s = c[7];
    if (sc == 8'hFF) return 16'h7FC0;                      // R1
    if (!fmt) begin
      e = c[6:3]; m = c[2:0];
      if (e == 15 && m == 7) return {s, 8'hFF, 7'h40};     // R3
      mag = (e == 0) ? m * (2.0 ** -9) : (1.0 + m / 8.0) * (2.0 ** real'(e - 7));
    end else begin
      e = c[6:2]; m = c[1:0];
      if (e == 31) return (m == 0) ? {s, 8'hFF, 7'h00} : {s, 8'hFF, 7'h40}; // R4
      mag = (e == 0) ? m * (2.0 ** -16) : (1.0 + m / 4.0) * (2.0 ** real'(e - 15));
    end
    if (mag == 0.0) return {s, 15'h0};                     // R8
    mag = mag * (2.0 ** real'(int'(sc) - 127));
    if (mag >= 2.0 ** 128) return {s, 8'hFF, 7'h00};       // R6
    if (mag >= 2.0 ** -126) begin                          // R2
      x = mag; ex = 0;
      while (x >= 2.0) begin x = x / 2.0; ex++; end
      while (x < 1.0)  begin x = x * 2.0; ex--; end
      return {s, 8'(ex + 127), 7'($rtoi((x - 1.0) * 128.0))};
    end
    return {s, 8'h00, 7'($rtoi(mag * (2.0 ** 133)))};      // R7
  endfunction

  function automatic string tag_of(logic [7:0] c, bit fmt, logic [7:0] sc, logic [15:0] r);
    if (sc == 8'hFF) return "R1";
    if (!fmt && c[6:0] == 7'h7F) return "R3";
    if (fmt && c[6:2] == 5'h1F) return "R4";
    if (c[6:0] == 7'h00) return "R8";
    if ((!fmt && c[6:3] == 0) || (fmt && c[6:2] == 0)) return "R5";
    if (r[14:7] == 8'hFF) return "R6";
    if (r[14:7] == 8'h00) return "R7";
    return "R2";
  endfunction

  task automatic send_block(bit fmt, logic [7:0] sc, int base);
    logic [7:0] c; logic [15:0] r; exp_t it;
    @(negedge clk);
    blk_fmt = fmt; blk_scale = sc; blk_valid = 1'b1;
    for (int i = 0; i < N; i++) begin
      c = 8'(base * N + i);
      blk_elems[8*i +: 8] = c;
      r = ref_bf(c, fmt, sc);
      it.data = r; it.idx = 5'(i); it.tag = tag_of(c, fmt, sc, r);
      q.push_back(it);
    end
    while (!blk_ready) @(negedge clk);
    @(negedge clk);
    chk(!blk_ready, "R10", "ready after capture", {31'd0, blk_ready}, 32'd0);
    blk_valid = 1'b0;
  endtask

  // monitor: consumer stall pattern, hold check and scoreboard
  logic [15:0] lfsr = 16'hACE1;
  bit          stall_prev = 0;
  logic [15:0] hold_d;
  logic [4:0]  hold_i;
  always @(negedge clk) begin
    exp_t it;
    if (rst) begin
      res_ready = 1'b0;
      stall_prev = 0;
    end else begin
      if (stall_prev) begin
        chk(res_valid && res_data == hold_d && res_idx == hold_i, "R10", "stalled result held",
            {res_valid, 10'd0, res_idx, res_data}, {1'b1, 10'd0, hold_i, hold_d});
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      res_ready = lfsr[0] | lfsr[1];
      stall_prev = res_valid && !res_ready;
      hold_d = res_data; hold_i = res_idx;
      if (res_valid && res_ready) begin
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected result", {16'd0, res_data}, 32'd0);
        end else begin
          it = q.pop_front();
          chk(res_data == it.data, it.tag, "value", {16'd0, res_data}, {16'd0, it.data});
          chk(res_idx == it.idx, "R9", "index", {27'd0, res_idx}, {27'd0, it.idx});
          chk(res_last == (it.idx == 5'd31), "R9", "last flag",
              {31'd0, res_last}, {31'd0, it.idx == 5'd31});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] scales [10] = '{8'd127, 8'd0, 8'd1, 8'd100, 8'd120,
                                8'd134, 8'd200, 8'd254, 8'd255, 8'd10};
    rst = 1'b1; blk_valid = 1'b0; blk_fmt = 1'b0; blk_scale = '0; blk_elems = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!res_valid, "R11", "res_valid after reset", {31'd0, res_valid}, 32'd0);
    chk(blk_ready, "R11", "blk_ready after reset", {31'd0, blk_ready}, 32'd1);
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 10; s++)
        for (int b = 0; b < 8; b++)
          send_block(f[0], scales[s], b);
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!res_valid, "R9", "no extra results", {31'd0, res_valid}, 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule